// File: doc/BRIEF.md
# Write Command Clock-Count Guard

This block protects the array of a three-wire serial memory from writes that were decoded out of a corrupted bit stream. From the serial front end it receives a strobe for the clock that carried the start bit, a strobe for every later serial-clock rising edge, the chip-select falling event and the command class that the neighbouring decoder settled on. It counts the serial clocks of each command from the start bit up to the deselect. When a write-type command ends, it issues a one-cycle commit pulse only if the count is exactly the length that class needs. In every other case it issues a one-cycle cancel pulse. A stray clock that turns a write-disable command into a single-word clear is caught this way.

The block also holds the write-enable state. An unlock command sets it and a lock command clears it, each taking effect when its command ends. A digital low-supply indication from an external voltage detector clears the state at once. The same indication spoils any command in flight, so after a supply dip nothing is written until a fresh unlock command arrives. Address width, data width and opcode width are parameters, and the expected lengths are derived from them.

Top module: `wr_guard_monitor`

## Requirements
- R1: Counting starts at 1 on the cycle `start_stb` is high with no command open, and each later `sk_rise_stb` adds one. `sk_rise_stb` pulses that come before any start bit (dummy clocks) are not counted.
- R2: A word-write (`cmd_class`=2) or fill-all (`cmd_class`=4) command needs exactly 1 + OPC_W + ADDR_W + DATA_W clocks, which is 25 with the defaults.
- R3: A word-clear (`cmd_class`=3) or clear-all (`cmd_class`=5) command needs exactly 1 + OPC_W + ADDR_W clocks, which is 9 with the defaults. One extra clock on such a command gives a cancel.
- R4: For a write-type command, any count above or below the required length gives a cancel. Clocks past the longest length put the counter into a saturated overflow state, and that state always gives a cancel.
- R5: The cycle after a `cs_fall` that closes an open command, a write-type command yields exactly one of `commit` or `cancel`, each high for one cycle. A command of any other class yields neither.
- R6: `wen` is 0 after reset. It becomes 1 one cycle after an unlock command (`cmd_class`=6) ends and 0 one cycle after a lock command (`cmd_class`=7) ends.
- R7: A write-type command that ends while `wen` is 0 is cancelled, even when its clock count is correct.
- R8: `low_supply` clears `wen` on the next cycle. A command that sees `low_supply` at any point from its start bit to its end is cancelled, and an unlock command that ends while `low_supply` is high leaves `wen` at 0.
- R9: Together with `commit`, `op_kind` reports the class of the committed command: 2 word-write, 3 word-clear, 4 fill-all, 5 clear-all. Class 0 is idle and class 1 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_stb | input | 1 | Serial clock edge that carried the start bit |
| sk_rise_stb | input | 1 | Serial clock rising-edge strobe |
| cs_fall | input | 1 | Chip-select falling event, ends the command |
| cmd_class | input | 3 | Decoded command class, valid with cs_fall |
| low_supply | input | 1 | Low-supply indication from the voltage detector |
| commit | output | 1 | One-cycle pulse: execute the write |
| cancel | output | 1 | One-cycle pulse: write command rejected |
| op_kind | output | 3 | Class of the committed command |
| wen | output | 1 | Write-enable state |

## Verification
Every result of this block is registered once. `commit`, `cancel`, `op_kind` and the update of `wen` after a command all show on the clock edge that samples `cs_fall`. A `low_supply` pulse clears `wen` on the edge that samples it. The bench drives inputs on falling clock edges and reads the outputs on the falling edge right after the sampling edge. Because the verdict pulses last only that one cycle, each pulse is seen in the one window where it is valid.

// File: rtl/wg_pkg.sv
package wg_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE     = 3'd0,
    CMD_READ     = 3'd1,
    CMD_WORD_WR  = 3'd2,
    CMD_WORD_CLR = 3'd3,
    CMD_ALL_WR   = 3'd4,
    CMD_ALL_CLR  = 3'd5,
    CMD_UNLOCK   = 3'd6,
    CMD_LOCK     = 3'd7
  } cmd_class_e;

  // Classes that alter the array and are guarded by the clock count.
  function automatic logic is_write_type(cmd_class_e c);
    return (c == CMD_WORD_WR) || (c == CMD_WORD_CLR) ||
           (c == CMD_ALL_WR)  || (c == CMD_ALL_CLR);
  endfunction

  // Classes followed by a data word on the wire.
  function automatic logic carries_data(cmd_class_e c);
    return (c == CMD_WORD_WR) || (c == CMD_ALL_WR);
  endfunction

  // Required clock count: start bit, opcode, address, optional data.
  function automatic int unsigned cmd_len(cmd_class_e c, int unsigned ow,
                                          int unsigned aw, int unsigned dw);
    int unsigned n;
    n = 1 + ow + aw;
    if (carries_data(c)) n = n + dw;
    return n;
  endfunction

endpackage

// File: rtl/wg_pulse_counter.sv
// Tracks one open command: counts serial clocks from the start bit and
// saturates into an overflow state past the longest legal length.
module wg_pulse_counter #(
  parameter int unsigned MAX_CNT = 25,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_stb,
  input  logic             sk_rise_stb,
  input  logic             cs_fall,
  input  logic             low_supply,
  output logic             session_active,
  output logic [CNT_W-1:0] clk_count,
  output logic             count_ovf,
  output logic             session_aborted,
  output logic             end_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CNT);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             abort_q;
  logic             open_evt;
  logic             step_evt;

  assign open_evt = start_stb && !armed_q;
  assign end_evt  = cs_fall && armed_q;
  assign step_evt = sk_rise_stb && armed_q && !cs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      abort_q <= 1'b0;
    end else if (open_evt) begin
      armed_q <= 1'b1;
      cnt_q   <= CNT_W'(1);
      ovf_q   <= 1'b0;
      abort_q <= low_supply;
    end else if (end_evt) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      if (step_evt) begin
        if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
        else                  cnt_q <= cnt_q + 1'b1;
      end
      if (low_supply) abort_q <= 1'b1;
    end
  end

  assign session_active  = armed_q;
  assign clk_count       = cnt_q;
  assign count_ovf       = ovf_q;
  assign session_aborted = abort_q;

endmodule

// File: rtl/wg_enable_latch.sv
// Holds the write-enable state; the supply detector wins over commands.
module wg_enable_latch (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_evt,
  input  wg_pkg::cmd_class_e cls,
  input  logic              low_supply,
  output logic              wen
);

  logic wen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    wen_q <= 1'b0;
    else if (low_supply)                           wen_q <= 1'b0;
    else if (end_evt && cls == wg_pkg::CMD_UNLOCK) wen_q <= 1'b1;
    else if (end_evt && cls == wg_pkg::CMD_LOCK)   wen_q <= 1'b0;
  end

  assign wen = wen_q;

endmodule

// File: rtl/wg_verdict.sv
// Compares the finished count with the class length and issues a verdict.
module wg_verdict #(
  parameter int unsigned OPC_W  = 2,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               end_evt,
  input  wg_pkg::cmd_class_e cls,
  input  logic [CNT_W-1:0]   clk_count,
  input  logic               count_ovf,
  input  logic               session_aborted,
  input  logic               low_supply,
  input  logic               wen,
  output logic               len_match,
  output logic               commit,
  output logic               cancel,
  output logic [2:0]         op_kind
);

  logic [CNT_W-1:0] exp_len;
  logic             guarded;
  logic             allow;
  logic             commit_q;
  logic             cancel_q;
  logic [2:0]       kind_q;

  assign exp_len   = CNT_W'(wg_pkg::cmd_len(cls, OPC_W, ADDR_W, DATA_W));
  assign len_match = !count_ovf && (clk_count == exp_len);
  assign guarded   = end_evt && wg_pkg::is_write_type(cls);
  assign allow     = len_match && wen && !session_aborted && !low_supply;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      cancel_q <= 1'b0;
      kind_q   <= 3'd0;
    end else begin
      commit_q <= guarded && allow;
      cancel_q <= guarded && !allow;
      if (guarded && allow) kind_q <= cls;
    end
  end

  assign commit  = commit_q;
  assign cancel  = cancel_q;
  assign op_kind = kind_q;

endmodule

// File: rtl/wr_guard_monitor.sv
module wr_guard_monitor #(
  parameter int unsigned OPC_W  = 2,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_stb,
  input  logic       sk_rise_stb,
  input  logic       cs_fall,
  input  logic [2:0] cmd_class,
  input  logic       low_supply,
  output logic       commit,
  output logic       cancel,
  output logic [2:0] op_kind,
  output logic       wen
);

  localparam int unsigned LONG_LEN = 1 + OPC_W + ADDR_W + DATA_W;
  localparam int unsigned CNT_W    = $clog2(LONG_LEN + 1);

  wg_pkg::cmd_class_e cls;
  logic               session_active;
  logic [CNT_W-1:0]   clk_count;
  logic               count_ovf;
  logic               session_aborted;
  logic               end_evt;
  logic               len_match;

  assign cls = wg_pkg::cmd_class_e'(cmd_class);

  wg_pulse_counter #(.MAX_CNT(LONG_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .start_stb, .sk_rise_stb, .cs_fall, .low_supply,
    .session_active, .clk_count, .count_ovf, .session_aborted, .end_evt
  );

  wg_enable_latch u_latch (
    .clk, .rst_n, .end_evt, .cls, .low_supply, .wen
  );

  wg_verdict #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_verdict (
    .clk, .rst_n, .end_evt, .cls, .clk_count, .count_ovf, .session_aborted,
    .low_supply, .wen, .len_match, .commit, .cancel, .op_kind
  );

endmodule

// File: rtl/wg_checker.sv
module wg_checker #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_stb,
  input logic             cs_fall,
  input logic             low_supply,
  input logic             session_active,
  input logic [CNT_W-1:0] clk_count,
  input logic             count_ovf,
  input logic             len_match,
  input logic             commit,
  input logic             cancel,
  input logic             wen
);

  // R5: never both verdicts at once
  assert_one_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, cancel}));

  // R5: a verdict only follows a closing chip-select fall
  assert_verdict_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || cancel) |-> $past(cs_fall && session_active));

  // R7: commit only with write enable held at the end of the command
  assert_commit_needs_wen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(wen));

  // R4: commit only on an exact, non-overflowed count
  assert_commit_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(len_match && !count_ovf));

  // R8: supply drop clears the enable on the next cycle
  assert_low_clears_wen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |=> !wen);

  // R1: dummy clocks with no open command leave the count untouched
  assert_dummy_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!session_active && !start_stb) |=> $stable(clk_count));

  // R4: overflow persists until the command closes
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_ovf && session_active && !cs_fall) |=> count_ovf);

endmodule

bind wr_guard_monitor wg_checker #(.CNT_W(CNT_W)) u_wg_checker (
  .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .cs_fall(cs_fall),
  .low_supply(low_supply), .session_active(session_active),
  .clk_count(clk_count), .count_ovf(count_ovf), .len_match(len_match),
  .commit(commit), .cancel(cancel), .wen(wen)
);

// File: tb/wr_guard_monitor_tb.sv
module wr_guard_monitor_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_stb = 1'b0;
  logic       sk_rise_stb = 1'b0;
  logic       cs_fall = 1'b0;
  logic [2:0] cmd_class = 3'd0;
  logic       low_supply = 1'b0;
  logic       commit;
  logic       cancel;
  logic [2:0] op_kind;
  logic       wen;

  int checks = 0;
  int errors = 0;
  bit wen_m  = 1'b0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wr_guard_monitor dut_i (
    .clk, .rst_n, .start_stb, .sk_rise_stb, .cs_fall, .cmd_class,
    .low_supply, .commit, .cancel, .op_kind, .wen
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Long commands: 1 start + 2 opcode + 6 address + 16 data; short: no data.
  function automatic int need_len(input int c);
    if (c == 2 || c == 4) return 25;
    return 9;
  endfunction

  // lowmode: 0 none, 1 pulse on the third clock, 2 held through the command
  task automatic run_cmd(input string req, input int c, input int nclk,
                         input int ndummy, input int lowmode);
    bit is_wr;
    bit exp_commit;
    for (int i = 0; i < ndummy; i++) begin
      @(negedge clk); sk_rise_stb = 1'b1;
    end
    @(negedge clk);
    start_stb = 1'b1; sk_rise_stb = 1'b1; low_supply = (lowmode == 2);
    for (int i = 1; i < nclk; i++) begin
      @(negedge clk);
      start_stb = 1'b0; sk_rise_stb = 1'b1;
      low_supply = (lowmode == 2) || (lowmode == 1 && i == 2);
    end
    @(negedge clk);
    start_stb = 1'b0; sk_rise_stb = 1'b0;
    low_supply = (lowmode == 2);
    cs_fall = 1'b1; cmd_class = 3'(c);
    @(negedge clk);
    cs_fall = 1'b0; cmd_class = 3'd0; low_supply = 1'b0;
    is_wr = (c >= 2 && c <= 5);
    exp_commit = is_wr && wen_m && (nclk == need_len(c)) && (lowmode == 0);
    if (lowmode == 2)      wen_m = 1'b0;
    else if (c == 6)       wen_m = 1'b1;
    else if (c == 7)       wen_m = 1'b0;
    else if (lowmode == 1) wen_m = 1'b0;
    chk({req, " commit"}, int'(commit), int'(exp_commit));
    chk({req, " cancel"}, int'(cancel), int'(is_wr && !exp_commit));
    chk({req, " wen"}, int'(wen), int'(wen_m));
    if (exp_commit) chk({req, " R9 op_kind"}, int'(op_kind), c);
    @(negedge clk);
    chk({req, " R5 single-cycle"}, int'(commit || cancel), 0);
  endtask

  task automatic t_reset();
    chk("R6 reset wen", int'(wen), 0);
    chk("R5 reset commit", int'(commit), 0);
    chk("R5 reset cancel", int'(cancel), 0);
  endtask

  task automatic t_locked();
    run_cmd("R7 write while locked", 2, 25, 0, 0);
    run_cmd("R7 clear-all while locked", 5, 9, 0, 0);
  endtask

  task automatic t_exact_lengths();
    run_cmd("R6 unlock", 6, 9, 0, 0);
    run_cmd("R2 word write 25", 2, 25, 0, 0);
    run_cmd("R2 fill-all 25", 4, 25, 0, 0);
    run_cmd("R3 word clear 9", 3, 9, 0, 0);
    run_cmd("R3 clear-all 9", 5, 9, 0, 0);
  endtask

  task automatic t_mismatch();
    run_cmd("R4 word write short", 2, 24, 0, 0);
    run_cmd("R4 word write long", 2, 26, 0, 0);
    run_cmd("R3 noisy lock as clear", 3, 10, 0, 0);
    run_cmd("R4 clear-all long", 5, 25, 0, 0);
    run_cmd("R4 overflow", 2, 40, 0, 0);
    run_cmd("R4 fill-all short", 4, 9, 0, 0);
  endtask

  task automatic t_dummy();
    run_cmd("R1 dummy clocks", 2, 25, 7, 0);
    run_cmd("R1 dummy clocks short", 3, 9, 5, 0);
  endtask

  task automatic t_other_classes();
    run_cmd("R5 read no verdict", 1, 25, 0, 0);
    run_cmd("R5 idle no verdict", 0, 9, 0, 0);
  endtask

  task automatic t_low_supply();
    run_cmd("R8 dip mid write", 2, 25, 0, 1);
    run_cmd("R8 write after dip", 2, 25, 0, 0);
    run_cmd("R8 unlock while low", 6, 9, 0, 2);
    run_cmd("R8 write still locked", 3, 9, 0, 0);
    run_cmd("R8 re-unlock", 6, 9, 0, 0);
    run_cmd("R8 write after re-unlock", 3, 9, 0, 0);
    @(negedge clk); low_supply = 1'b1;
    @(negedge clk); low_supply = 1'b0; wen_m = 1'b0;
    chk("R8 idle dip clears wen", int'(wen), 0);
  endtask

  task automatic t_lock();
    run_cmd("R6 unlock again", 6, 9, 0, 0);
    run_cmd("R6 lock", 7, 9, 0, 0);
    run_cmd("R7 write after lock", 2, 25, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_locked();
    t_exact_lengths();
    t_mismatch();
    t_dummy();
    t_other_classes();
    t_low_supply();
    t_lock();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule